// File: doc/BRIEF.md
# Accumulator ALU with Nibble Carry

This block is the purely combinational arithmetic and logic unit of a small accumulator-based processor core. Each cycle the decoder presents an operation code, the accumulator value (operand A), a second operand (B), and the current carry and half-carry flags. The block returns the 8-bit result, the proposed new values of the carry (C), half carry (AC), zero (Z) and overflow (OV) flags, and one enable per flag. The enable tells the flag register whether that flag should be written. The core's writeback and decode logic stay outside the block. They latch the result and the enabled flags.

The operations cover several groups. The binary arithmetic group is add and subtract, each with and without the incoming carry. A decimal adjust corrects a packed-BCD sum. The remaining groups are four bitwise operations, four rotates, increment and decrement, and a pass-through zero test that drives skip decisions. In subtraction, both carries use the "no borrow" sense. Overflow is the mismatch between the carry into bit 7 and the carry out of bit 7.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives A+B and ADC (code 1) gives A+B+C. In both, C is the carry out of bit 7.
- R2: SUB (code 2) gives A + ~B + 1 and SBC (code 3) gives A + ~B + C. In both, C reads 1 when no borrow occurs, which is the carry out of that sum.
- R3: For codes 0 to 3, AC is the carry out of bit 3 of the same sum. In subtraction this means AC reads 1 when the low nibble does not borrow.
- R4: For codes 0 to 3, OV is the carry into bit 7 XOR the carry out of bit 7.
- R5: When the Z enable is high, Z is 1 exactly when the result is zero. The output o_zero reflects result==0 for every code.
- R6: DAA (code 4) works on A. Let S be the adjustment, which starts at 0. S gains 06h when A[3:0]>9 or AC=1. S then gains 60h when bits 7:4 of A plus the low part of S exceed 9, or when C=1. The result is A+S, C becomes the carry out of bit 7, and only C is enabled.
- R7: AND (5), OR (6), XOR (7) combine A with B, and CPL (8) gives ~A. Only Z is enabled.
- R8: RL (9) rotates A left and RR (10) rotates A right, both within 8 bits. No flag is enabled.
- R9: RLC (11) rotates {C,A} left and RRC (12) rotates {A,C} right through the carry. The outgoing bit becomes C, and only C is enabled.
- R10: INC (13) gives A+1 and DEC (14) gives A-1, both wrapping modulo 256. Only Z is enabled.
- R11: TST (15) passes A to the result and enables no flag. Skip decisions use o_zero.
- R12: A flag output whose enable is low reads 0. For codes 0 to 3 all four enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_op | input | 4 | Operation code (see requirements) |
| i_a | input | 8 | Operand A (accumulator side) |
| i_b | input | 8 | Operand B |
| i_c | input | 1 | Current carry flag |
| i_ac | input | 1 | Current half-carry flag |
| o_res | output | 8 | Operation result |
| o_c | output | 1 | Next carry value |
| o_ac | output | 1 | Next half-carry value |
| o_z | output | 1 | Next zero value |
| o_ov | output | 1 | Next overflow value |
| o_c_en | output | 1 | Write enable for C |
| o_ac_en | output | 1 | Write enable for AC |
| o_z_en | output | 1 | Write enable for Z |
| o_ov_en | output | 1 | Write enable for OV |
| o_zero | output | 1 | Result-is-zero indication for skips |

## Verification
The embedded checks are immediate assertions. They assume that the operation code and operands are settled two-state values when the combinational logic evaluates. They also assume that DAA is used as a correction after an addition, although its adjustment check holds for any operand. The bench changes inputs only on the falling clock edge and samples one nanosecond later, so every value is stable and defined when a check runs. Both the directed corner vectors and the random sweep cover all sixteen codes with arbitrary carry and half-carry inputs. No operand pattern falls outside what the assertions allow.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_DAA = 4'd4,
      OP_AND = 4'd5,
      OP_OR  = 4'd6,
      OP_XOR = 4'd7,
      OP_CPL = 4'd8,
      OP_RL  = 4'd9,
      OP_RR  = 4'd10,
      OP_RLC = 4'd11,
      OP_RRC = 4'd12,
      OP_INC = 4'd13,
      OP_DEC = 4'd14,
      OP_TST = 4'd15
   } alu_op_t;

   typedef struct packed {
      logic c;
      logic ac;
      logic z;
      logic ov;
   } flag_set_t;

   localparam int NIBBLE_W = 4;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
   parameter int W     = 8,
   parameter int NIB_W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         invert_b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         half_c,
   output logic         ovf
);
   localparam int LOW_W = W - 1;

   logic [W-1:0]     b_eff;
   logic [W:0]       full;
   logic [NIB_W:0]   low_nib;
   logic [LOW_W:0]   below_top;
   logic             c_into_top;

   always_comb begin
      b_eff      = invert_b ? ~b : b;
      full       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      low_nib    = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
      below_top  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
      c_into_top = below_top[LOW_W];
      sum        = full[W-1:0];
      cout       = full[W];
      half_c     = low_nib[NIB_W];
      ovf        = c_into_top ^ cout;
   end

   // R4: carry mismatch must agree with the signed-operand rule
   always_comb begin
      ovf_sign_chk: assert (ovf == ((a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1])));
   end
endmodule

// File: rtl/alu8_rotate.sv
`timescale 1ns/1ps
module alu8_rotate #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         cin,
   input  logic         left,
   input  logic         through,
   output logic [W-1:0] res,
   output logic         cout
);
   logic fill_lo;
   logic fill_hi;

   always_comb begin
      fill_lo = through ? cin : a[W-1];
      fill_hi = through ? cin : a[0];
      if (left) begin
         res  = {a[W-2:0], fill_lo};
         cout = a[W-1];
      end else begin
         res  = {fill_hi, a[W-1:1]};
         cout = a[0];
      end
   end

   // R8 R9: a rotation conserves the ones in the rotated ring
   always_comb begin
      if (through) begin
         rot_ring_chk: assert ($countones({cout, res}) == $countones({cin, a}));
      end else begin
         rot_plain_chk: assert ($countones(res) == $countones(a));
      end
   end
endmodule

// File: rtl/alu8_decadj.sv
`timescale 1ns/1ps
module alu8_decadj #(
   parameter int W     = 8,
   parameter int NIB_W = 4
) (
   input  logic [W-1:0] a,
   input  logic         c_in,
   input  logic         ac_in,
   output logic [W-1:0] res,
   output logic         c_out
);
   localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
   localparam logic [W-1:0]     LOW_FIX   = W'(6);
   localparam logic [W-1:0]     HIGH_FIX  = W'(6) << NIB_W;

   logic [W-1:0] adj;
   logic [W:0]   step1;
   logic [W:0]   total;

   always_comb begin
      adj = '0;
      if (a[NIB_W-1:0] > DIGIT_MAX || ac_in) adj = LOW_FIX;
      step1 = {1'b0, a} + {1'b0, adj};
      if (step1[W-1:NIB_W] > DIGIT_MAX || c_in) adj = adj | HIGH_FIX;
      total = {1'b0, a} + {1'b0, adj};
      res   = total[W-1:0];
      c_out = total[W];
   end

   // R6: the correction applied is one of the four legal adjustments
   always_comb begin
      daa_step_chk: assert (((res - a) == '0) || ((res - a) == LOW_FIX) ||
                            ((res - a) == HIGH_FIX) || ((res - a) == (LOW_FIX | HIGH_FIX)));
   end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit HAS_DAA = 1'b1
) (
   input  logic [3:0]        i_op,
   input  logic [DATA_W-1:0] i_a,
   input  logic [DATA_W-1:0] i_b,
   input  logic              i_c,
   input  logic              i_ac,
   output logic [DATA_W-1:0] o_res,
   output logic              o_c,
   output logic              o_ac,
   output logic              o_z,
   output logic              o_ov,
   output logic              o_c_en,
   output logic              o_ac_en,
   output logic              o_z_en,
   output logic              o_ov_en,
   output logic              o_zero
);
   localparam logic [DATA_W-1:0] UNIT = DATA_W'(1);

   generate
      if (DATA_W % NIBBLE_W != 0 || DATA_W < 2 * NIBBLE_W) begin : g_bad_width
         $error("alu8_core: DATA_W must be a multiple of the nibble width and at least two nibbles");
      end
      if (HAS_DAA && DATA_W != 2 * NIBBLE_W) begin : g_bad_daa
         $error("alu8_core: decimal adjust needs exactly two nibbles");
      end
   endgenerate

   alu_op_t op;
   assign op = alu_op_t'(i_op);

   logic              as_inv;
   logic              as_cin;
   logic [DATA_W-1:0] as_sum;
   logic              as_cout;
   logic              as_half;
   logic              as_ovf;

   always_comb begin
      as_inv = (op == OP_SUB) || (op == OP_SBC);
      unique case (op)
         OP_ADD:  as_cin = 1'b0;
         OP_SUB:  as_cin = 1'b1;
         default: as_cin = i_c;
      endcase
   end

   alu8_addsub #(.W(DATA_W), .NIB_W(NIBBLE_W)) u_addsub (
      .a(i_a), .b(i_b), .invert_b(as_inv), .cin(as_cin),
      .sum(as_sum), .cout(as_cout), .half_c(as_half), .ovf(as_ovf)
   );

   logic              rot_left;
   logic              rot_thru;
   logic [DATA_W-1:0] rot_res;
   logic              rot_cout;

   assign rot_left = (op == OP_RL)  || (op == OP_RLC);
   assign rot_thru = (op == OP_RLC) || (op == OP_RRC);

   alu8_rotate #(.W(DATA_W)) u_rotate (
      .a(i_a), .cin(i_c), .left(rot_left), .through(rot_thru),
      .res(rot_res), .cout(rot_cout)
   );

   logic [DATA_W-1:0] daa_res;
   logic              daa_c;

   generate
      if (HAS_DAA) begin : g_daa
         alu8_decadj #(.W(DATA_W), .NIB_W(NIBBLE_W)) u_decadj (
            .a(i_a), .c_in(i_c), .ac_in(i_ac), .res(daa_res), .c_out(daa_c)
         );
      end else begin : g_no_daa
         assign daa_res = i_a;
         assign daa_c   = i_c;
      end
   endgenerate

   flag_set_t nxt;
   flag_set_t en;
   logic      res_is_zero;

   always_comb begin
      o_res = i_a;
      nxt   = '0;
      en    = '0;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            o_res  = as_sum;
            nxt.c  = as_cout;
            nxt.ac = as_half;
            nxt.ov = as_ovf;
            en     = '1;
         end
         OP_DAA: begin
            o_res = daa_res;
            nxt.c = daa_c;
            en.c  = 1'b1;
         end
         OP_AND: begin o_res = i_a & i_b; en.z = 1'b1; end
         OP_OR:  begin o_res = i_a | i_b; en.z = 1'b1; end
         OP_XOR: begin o_res = i_a ^ i_b; en.z = 1'b1; end
         OP_CPL: begin o_res = ~i_a;      en.z = 1'b1; end
         OP_RL, OP_RR: o_res = rot_res;
         OP_RLC, OP_RRC: begin
            o_res = rot_res;
            nxt.c = rot_cout;
            en.c  = 1'b1;
         end
         OP_INC: begin o_res = i_a + UNIT; en.z = 1'b1; end
         OP_DEC: begin o_res = i_a - UNIT; en.z = 1'b1; end
         default: o_res = i_a;
      endcase
      res_is_zero = (o_res == '0);
      nxt.z       = en.z & res_is_zero;
   end

   assign o_c     = nxt.c;
   assign o_ac    = nxt.ac;
   assign o_z     = nxt.z;
   assign o_ov    = nxt.ov;
   assign o_c_en  = en.c;
   assign o_ac_en = en.ac;
   assign o_z_en  = en.z;
   assign o_ov_en = en.ov;
   assign o_zero  = res_is_zero;

   // R12: a flag that will not be written is driven low
   always_comb begin
      quiet_flag_chk: assert (((o_c & ~o_c_en) | (o_ac & ~o_ac_en) |
                               (o_z & ~o_z_en) | (o_ov & ~o_ov_en)) == 1'b0);
   end

   // R5: an enabled Z agrees with the skip indication
   always_comb begin
      if (o_z_en) begin
         zero_flag_chk: assert (o_z == o_zero);
      end
   end

   // R12: overflow and half carry are written together, only by arithmetic
   always_comb begin
      ovac_pair_chk: assert ((o_ov_en == o_ac_en) && (!o_ov_en || (o_c_en && o_z_en)));
   end
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op;
   logic [7:0] a, b;
   logic       c, ac;
   logic [7:0] res;
   logic       fc, fac, fz, fov, ec, eac, ez, eov, zero;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   alu8_core i_alu8_core (
      .i_op(op), .i_a(a), .i_b(b), .i_c(c), .i_ac(ac),
      .o_res(res), .o_c(fc), .o_ac(fac), .o_z(fz), .o_ov(fov),
      .o_c_en(ec), .o_ac_en(eac), .o_z_en(ez), .o_ov_en(eov), .o_zero(zero)
   );

   // expected {en c,ac,z,ov, flags c,ac,z,ov, result}
   function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] x,
                                         input logic [7:0] y, input logic ci, input logic aci);
      logic [7:0] r, yy, adj;
      logic [8:0] s, t;
      logic [4:0] lo;
      logic       k, qc, qac, qov;
      logic [3:0] e;
      r = x; qc = 0; qac = 0; qov = 0; e = 4'b0000;
      case (o)
         4'd0, 4'd1, 4'd2, 4'd3: begin
            yy = (o >= 4'd2) ? ~y : y;
            k  = (o == 4'd0) ? 1'b0 : (o == 4'd2) ? 1'b1 : ci;
            s  = {1'b0, x} + {1'b0, yy} + {8'd0, k};
            lo = {1'b0, x[3:0]} + {1'b0, yy[3:0]} + {4'd0, k};
            r = s[7:0]; qc = s[8]; qac = lo[4];
            qov = (x[7] == yy[7]) && (r[7] != x[7]);
            e = 4'b1111;
         end
         4'd4: begin
            adj = 8'h00;
            if (x[3:0] > 4'd9 || aci) adj = 8'h06;
            t = {1'b0, x} + {1'b0, adj};
            if (t[7:4] > 4'd9 || ci) adj = adj + 8'h60;
            s = {1'b0, x} + {1'b0, adj};
            r = s[7:0]; qc = s[8]; e = 4'b1000;
         end
         4'd5: begin r = x & y; e = 4'b0010; end
         4'd6: begin r = x | y; e = 4'b0010; end
         4'd7: begin r = x ^ y; e = 4'b0010; end
         4'd8: begin r = ~x;    e = 4'b0010; end
         4'd9:  r = {x[6:0], x[7]};
         4'd10: r = {x[0], x[7:1]};
         4'd11: begin r = {x[6:0], ci}; qc = x[7]; e = 4'b1000; end
         4'd12: begin r = {ci, x[7:1]}; qc = x[0]; e = 4'b1000; end
         4'd13: begin r = x + 8'd1; e = 4'b0010; end
         4'd14: begin r = x - 8'd1; e = 4'b0010; end
         default: r = x;
      endcase
      return {e, qc, qac, e[1] & (r == 8'd0), qov, r};
   endfunction

   task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic ci, input logic aci);
      @(negedge clk);
      op = o; a = x; b = y; c = ci; ac = aci;
      #1;
   endtask

   task automatic compare(input string tag, input logic [15:0] exp);
      logic [15:0] got;
      got = {ec, eac, ez, eov, fc, fac, fz, fov, res};
      n_vec++;
      if (got !== exp || zero !== (exp[7:0] == 8'd0)) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h c=%b ac=%b: got %h zero=%b, expected %h zero=%b",
                  tag, op, a, b, c, ac, got, zero, exp, (exp[7:0] == 8'd0));
      end
   endtask

   task automatic apply(input string tag, input logic [3:0] o, input logic [7:0] x,
                        input logic [7:0] y, input logic ci, input logic aci,
                        input logic [15:0] exp);
      drive(o, x, y, ci, aci);
      compare(tag, exp);
   endtask

   task automatic t_reset_state;
      // R11 R12: idle inputs give a pass-through zero with no flag written
      apply("R11 idle", 4'd15, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000);
   endtask

   task automatic t_add;
      apply("R1 R3 R5 add wrap", 4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 16'hFE00);
      apply("R4 add ov",         4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 16'hF580);
      apply("R1 adc carry in",   4'd1, 8'h10, 8'h20, 1'b1, 1'b0, 16'hF031);
   endtask

   task automatic t_sub;
      apply("R2 R3 sub nibble borrow", 4'd2, 8'h10, 8'h01, 1'b0, 1'b0, 16'hF80F);
      apply("R2 sub borrow",           4'd2, 8'h00, 8'h01, 1'b1, 1'b0, 16'hF0FF);
      apply("R4 sbc ov",               4'd3, 8'h80, 8'h01, 1'b1, 1'b0, 16'hF97F);
      apply("R2 sbc borrow in",        4'd3, 8'h05, 8'h05, 1'b0, 1'b0, 16'hF0FF);
   endtask

   task automatic t_daa;
      apply("R6 daa half carry", 4'd4, 8'h12, 8'h00, 1'b0, 1'b1, 16'h8018);
      apply("R6 daa both",       4'd4, 8'h9A, 8'h00, 1'b0, 1'b0, 16'h8800);
      apply("R6 daa carry kept", 4'd4, 8'h00, 8'h00, 1'b1, 1'b0, 16'h8060);
   endtask

   task automatic t_logic;
      apply("R7 and zero", 4'd5, 8'hF0, 8'h0F, 1'b1, 1'b1, 16'h2200);
      apply("R7 or",       4'd6, 8'hF0, 8'h0F, 1'b0, 1'b0, 16'h20FF);
      apply("R7 xor",      4'd7, 8'hAA, 8'hAA, 1'b0, 1'b0, 16'h2200);
      apply("R7 cpl",      4'd8, 8'h5A, 8'h00, 1'b1, 1'b0, 16'h20A5);
   endtask

   task automatic t_rotate;
      apply("R8 rl",  4'd9,  8'h81, 8'h00, 1'b0, 1'b0, 16'h0003);
      apply("R8 rr",  4'd10, 8'h01, 8'h00, 1'b1, 1'b0, 16'h0080);
      apply("R9 rlc", 4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 16'h8800);
      apply("R9 rrc", 4'd12, 8'h01, 8'h00, 1'b1, 1'b0, 16'h8880);
   endtask

   task automatic t_incdec;
      apply("R10 inc wrap", 4'd13, 8'hFF, 8'h00, 1'b0, 1'b0, 16'h2200);
      apply("R10 dec wrap", 4'd14, 8'h00, 8'h00, 1'b1, 1'b1, 16'h20FF);
   endtask

   task automatic t_test;
      apply("R11 tst nonzero", 4'd15, 8'h3C, 8'hFF, 1'b1, 1'b1, 16'h003C);
   endtask

   task automatic t_sweep;
      // R1..R12 all codes, random operands, against the requirement model
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] o;
         logic [7:0] x, y;
         logic       ci, aci;
         o = 4'(i % 16); x = 8'($urandom); y = 8'($urandom);
         ci = 1'($urandom); aci = 1'($urandom);
         apply("R12 sweep", o, x, y, ci, aci, model(o, x, y, ci, aci));
      end
   endtask

   initial begin
      op = 4'd15; a = 8'h00; b = 8'h00; c = 1'b0; ac = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_daa();
      t_logic();
      t_rotate();
      t_incdec();
      t_test();
      t_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule